// File: doc/BRIEF.md
# Write Data Poison Handler

This block guards the write path between an ingress stream of write-data beats and the memory interface. Each beat may arrive with an integrity flag. One flag reports a parity failure seen when the beat left the clock-crossing FIFO. The other reports an uncorrectable ECC failure on the received data flit. Either flag is turned into a poison mark that travels with the beat into the write buffer. The buffer storage itself lives outside this block.

When a buffered beat is later read out toward memory, the block makes sure corrupted data cannot reach memory unnoticed. With memory ECC enabled, it computes the check bits and then flips two fixed check bits, so a later read sees an uncorrectable error. With ECC disabled, it clears every byte enable, so the write changes nothing. A poisoned beat still uses its normal write slot. A separate parity failure on data pulled from the buffer is reported as its own event. Every error event is a one-cycle pulse that a status register can capture.

Top module: `wdp_poison_handler`

## Requirements
- R1: `in_ready` equals `buf_wr_ready` in the same cycle. A beat is accepted when `in_valid` and `in_ready` are both high. Each accepted beat appears on the buffer write port (`buf_wr_en` high, `buf_wr_data` equal to `in_data`) exactly one cycle later. No buffer write happens in a cycle that follows a cycle with no accepted beat.
- R2: `buf_wr_poison` is high on a buffer write if and only if the accepted beat carried `in_fifo_par_err` or `in_flit_ecc_err` (or both).
- R3: `ev_fifo_par` and `ev_flit_ecc` each pulse for one cycle, together with the buffer write of an accepted beat carrying the matching flag. A flag on a beat that is not accepted produces no pulse.
- R4: Every cycle with `rd_valid` high produces exactly one memory beat (`mem_valid` high) one cycle later, whether or not the beat is poisoned. `mem_valid` is low in every other cycle.
- R5: The check bits are computed per byte as even parity: bit i of the generated code is the XOR of data bits [8i+7:8i]. `mem_data` always equals `rd_data` of the beat.
- R6: In ECC mode, a clean beat gets all byte enables set and `mem_ecc` equal to the generated code.
- R7: In ECC mode, a poisoned beat gets all byte enables set and `mem_ecc` equal to the generated code with bits 0 and 1 inverted.
- R8: In mask mode, a poisoned beat gets `mem_byte_en` all zero. Every beat in mask mode gets `mem_ecc` all zero.
- R9: In mask mode, a clean beat gets all byte enables set.
- R10: The protection mode is taken from `cfg_ecc_en` (1 = ECC mode, 0 = mask mode) on the beat that has `rd_first` high. Later beats of the burst use that stored mode, and changes of `cfg_ecc_en` on those beats have no effect. After reset the stored mode is mask mode.
- R11: `ev_buf_par` pulses for one cycle, together with the memory beat of a read beat that had `rd_buf_par_err` high. The data, byte enables and check bits of that beat are not altered by the flag.
- R12: After reset, `buf_wr_en`, `buf_wr_poison`, `mem_valid` and all three event outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Ingress beat valid |
| in_ready | output | 1 | Ingress beat ready |
| in_data | input | DW | Ingress beat data |
| in_fifo_par_err | input | 1 | Beat had a parity error leaving the clock-crossing FIFO |
| in_flit_ecc_err | input | 1 | Beat's data flit had an uncorrectable ECC error |
| buf_wr_ready | input | 1 | Write buffer can take a beat |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wr_data | output | DW | Buffer write data |
| buf_wr_poison | output | 1 | Poison mark stored with the beat |
| ev_fifo_par | output | 1 | Pulse: FIFO parity error on an accepted beat |
| ev_flit_ecc | output | 1 | Pulse: flit ECC error on an accepted beat |
| cfg_ecc_en | input | 1 | Memory ECC enabled (sampled on first beat of a burst) |
| rd_valid | input | 1 | Beat read from the buffer toward memory |
| rd_first | input | 1 | First beat of a burst |
| rd_data | input | DW | Buffered beat data |
| rd_poison | input | 1 | Stored poison mark of the beat |
| rd_buf_par_err | input | 1 | Parity error on the data pulled from the buffer |
| mem_valid | output | 1 | Memory write beat valid |
| mem_data | output | DW | Memory write data |
| mem_byte_en | output | DW/8 | Byte enables (1 = write the byte) |
| mem_ecc | output | DW/8 | Check bits |
| ev_buf_par | output | 1 | Pulse: buffer parity error on a beat |

## Verification
Ingress beats are sent with no flag, with each flag alone and with both flags. Some flagged beats are sent while the buffer is not ready, which shows that poison and events come only from accepted beats. Read bursts mix clean and poisoned beats in both modes, so the four outcomes are told apart: plain code, code with two flipped bits, all-masked and fully enabled. A burst toggles `cfg_ecc_en` after its first beat, which separates per-burst sampling from per-beat sampling. Long random mixes on both sides, with idle gaps, check that beat counts stay intact.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
    typedef enum logic {
        PROT_MASK = 1'b0,
        PROT_ECC  = 1'b1
    } prot_mode_e;
endpackage

// File: rtl/wdp_ecc_gen.sv
module wdp_ecc_gen #(
    parameter int DW = 64,
    localparam int EW = DW / 8
) (
    input  logic [DW-1:0] data,
    output logic [EW-1:0] code
);
    for (genvar g = 0; g < EW; g++) begin : g_byte
        assign code[g] = ^data[8*g +: 8];
    end
endmodule

// File: rtl/wdp_ingress.sv
module wdp_ingress #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_fifo_par_err,
    input  logic          in_flit_ecc_err,
    input  logic          buf_wr_ready,
    output logic          buf_wr_en,
    output logic [DW-1:0] buf_wr_data,
    output logic          buf_wr_poison,
    output logic          ev_fifo_par,
    output logic          ev_flit_ecc
);
    typedef struct packed {
        logic          wr_en;
        logic [DW-1:0] data;
        logic          poison;
        logic          ev_par;
        logic          ev_ecc;
    } ing_st_t;

    ing_st_t st_d, st_q;
    logic    take;

    assign in_ready = buf_wr_ready;
    assign take     = in_valid & buf_wr_ready;

    always_comb begin
        st_d        = st_q;
        st_d.wr_en  = take;
        st_d.poison = take & (in_fifo_par_err | in_flit_ecc_err);
        st_d.ev_par = take & in_fifo_par_err;
        st_d.ev_ecc = take & in_flit_ecc_err;
        if (take) begin
            st_d.data = in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_wr_en     = st_q.wr_en;
    assign buf_wr_data   = st_q.data;
    assign buf_wr_poison = st_q.poison;
    assign ev_fifo_par   = st_q.ev_par;
    assign ev_flit_ecc   = st_q.ev_ecc;
endmodule

// File: rtl/wdp_egress.sv
module wdp_egress
    import wdp_pkg::*;
#(
    parameter int DW    = 64,
    parameter int INJ_A = 0,
    parameter int INJ_B = 1,
    localparam int EW   = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_ecc_en,
    input  logic          rd_valid,
    input  logic          rd_first,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_poison,
    input  logic          rd_buf_par_err,
    input  logic [EW-1:0] gen_code,
    output logic          mem_valid,
    output logic [DW-1:0] mem_data,
    output logic [EW-1:0] mem_byte_en,
    output logic [EW-1:0] mem_ecc,
    output logic          ev_buf_par
);
    localparam logic [EW-1:0] INJ_MASK = (EW'(1) << INJ_A) | (EW'(1) << INJ_B);

    typedef struct packed {
        prot_mode_e    mode;
        logic          valid;
        logic [DW-1:0] data;
        logic [EW-1:0] be;
        logic [EW-1:0] ecc;
        logic          ev_par;
    } egr_st_t;

    egr_st_t    st_d, st_q;
    prot_mode_e beat_mode;

    always_comb begin
        st_d      = st_q;
        beat_mode = st_q.mode;
        if (rd_valid && rd_first) begin
            beat_mode = cfg_ecc_en ? PROT_ECC : PROT_MASK;
            st_d.mode = beat_mode;
        end
        st_d.valid  = rd_valid;
        st_d.ev_par = rd_valid & rd_buf_par_err;
        if (rd_valid) begin
            st_d.data = rd_data;
            if (beat_mode == PROT_ECC) begin
                st_d.be  = '1;
                st_d.ecc = rd_poison ? (gen_code ^ INJ_MASK) : gen_code;
            end else begin
                st_d.be  = rd_poison ? '0 : '1;
                st_d.ecc = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= PROT_MASK;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_valid   = st_q.valid;
    assign mem_data    = st_q.data;
    assign mem_byte_en = st_q.be;
    assign mem_ecc     = st_q.ecc;
    assign ev_buf_par  = st_q.ev_par;
endmodule

// File: rtl/wdp_poison_handler.sv
module wdp_poison_handler #(
    parameter int DW    = 64,
    parameter int INJ_A = 0,
    parameter int INJ_B = 1,
    localparam int EW   = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_fifo_par_err,
    input  logic          in_flit_ecc_err,
    input  logic          buf_wr_ready,
    output logic          buf_wr_en,
    output logic [DW-1:0] buf_wr_data,
    output logic          buf_wr_poison,
    output logic          ev_fifo_par,
    output logic          ev_flit_ecc,
    input  logic          cfg_ecc_en,
    input  logic          rd_valid,
    input  logic          rd_first,
    input  logic [DW-1:0] rd_data,
    input  logic          rd_poison,
    input  logic          rd_buf_par_err,
    output logic          mem_valid,
    output logic [DW-1:0] mem_data,
    output logic [EW-1:0] mem_byte_en,
    output logic [EW-1:0] mem_ecc,
    output logic          ev_buf_par
);
    logic [EW-1:0] gen_code;

    wdp_ingress #(.DW(DW)) u_ing (
        .clk             (clk),
        .rst_n           (rst_n),
        .in_valid        (in_valid),
        .in_ready        (in_ready),
        .in_data         (in_data),
        .in_fifo_par_err (in_fifo_par_err),
        .in_flit_ecc_err (in_flit_ecc_err),
        .buf_wr_ready    (buf_wr_ready),
        .buf_wr_en       (buf_wr_en),
        .buf_wr_data     (buf_wr_data),
        .buf_wr_poison   (buf_wr_poison),
        .ev_fifo_par     (ev_fifo_par),
        .ev_flit_ecc     (ev_flit_ecc)
    );

    wdp_ecc_gen #(.DW(DW)) u_gen (
        .data (rd_data),
        .code (gen_code)
    );

    wdp_egress #(.DW(DW), .INJ_A(INJ_A), .INJ_B(INJ_B)) u_egr (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_ecc_en     (cfg_ecc_en),
        .rd_valid       (rd_valid),
        .rd_first       (rd_first),
        .rd_data        (rd_data),
        .rd_poison      (rd_poison),
        .rd_buf_par_err (rd_buf_par_err),
        .gen_code       (gen_code),
        .mem_valid      (mem_valid),
        .mem_data       (mem_data),
        .mem_byte_en    (mem_byte_en),
        .mem_ecc        (mem_ecc),
        .ev_buf_par     (ev_buf_par)
    );
endmodule

// File: rtl/wdp_poison_checker.sv
module wdp_poison_checker #(
    parameter int DW = 64,
    localparam int EW = DW / 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          in_fifo_par_err,
    input logic          in_flit_ecc_err,
    input logic          buf_wr_ready,
    input logic          buf_wr_en,
    input logic          buf_wr_poison,
    input logic          ev_fifo_par,
    input logic          ev_flit_ecc,
    input logic          rd_valid,
    input logic          rd_buf_par_err,
    input logic          mem_valid,
    input logic [EW-1:0] mem_byte_en,
    input logic [EW-1:0] mem_ecc,
    input logic          ev_buf_par
);
    a_r1_ready_follows_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready == buf_wr_ready);

    a_r1_accept_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> buf_wr_en);

    a_r1_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> !buf_wr_en);

    a_r2_flag_poisons: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (in_fifo_par_err || in_flit_ecc_err)) |=> buf_wr_poison);

    a_r3_par_event_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        ev_fifo_par |-> (buf_wr_en && buf_wr_poison));

    a_r3_ecc_event_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        ev_flit_ecc |-> (buf_wr_en && buf_wr_poison));

    a_r4_beat_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> mem_valid);

    a_r4_no_extra_beat: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |=> !mem_valid);

    a_r8_masked_has_no_code: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_byte_en == '0) |-> (mem_ecc == '0));

    a_r11_buf_par_event: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_buf_par_err) |=> ev_buf_par);

    a_r11_event_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
        ev_buf_par |-> mem_valid);
endmodule

bind wdp_poison_handler wdp_poison_checker #(.DW(DW)) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .in_valid        (in_valid),
    .in_ready        (in_ready),
    .in_fifo_par_err (in_fifo_par_err),
    .in_flit_ecc_err (in_flit_ecc_err),
    .buf_wr_ready    (buf_wr_ready),
    .buf_wr_en       (buf_wr_en),
    .buf_wr_poison   (buf_wr_poison),
    .ev_fifo_par     (ev_fifo_par),
    .ev_flit_ecc     (ev_flit_ecc),
    .rd_valid        (rd_valid),
    .rd_buf_par_err  (rd_buf_par_err),
    .mem_valid       (mem_valid),
    .mem_byte_en     (mem_byte_en),
    .mem_ecc         (mem_ecc),
    .ev_buf_par      (ev_buf_par)
);

// File: tb/test_wdp_poison_handler.sv
module test_wdp_poison_handler;
    localparam int DW = 64;
    localparam int EW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, in_ready, in_fifo_par_err, in_flit_ecc_err, buf_wr_ready;
    logic [DW-1:0] in_data;
    logic          buf_wr_en, buf_wr_poison, ev_fifo_par, ev_flit_ecc;
    logic [DW-1:0] buf_wr_data;
    logic          cfg_ecc_en, rd_valid, rd_first, rd_poison, rd_buf_par_err;
    logic [DW-1:0] rd_data;
    logic          mem_valid, ev_buf_par;
    logic [DW-1:0] mem_data;
    logic [EW-1:0] mem_byte_en, mem_ecc;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // reference state
    bit            mdl_ecc_mode;
    bit            x_wr_en, x_poison, x_evp, x_eve, x_mv, x_evb;
    logic [DW-1:0] x_wr_data, x_md;
    logic [EW-1:0] x_be, x_ecc;

    always #2.5 clk = ~clk;

    wdp_poison_handler i_wdp_poison_handler (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] byte_parity(input logic [DW-1:0] d);
        logic [EW-1:0] r;
        for (int i = 0; i < EW; i++) begin
            r[i] = 1'b0;
            for (int b = 0; b < 8; b++) r[i] = r[i] ^ d[8*i + b];
        end
        return r;
    endfunction

    task automatic idle();
        in_valid = 0; in_data = '0; in_fifo_par_err = 0; in_flit_ecc_err = 0;
        rd_valid = 0; rd_first = 0; rd_data = '0; rd_poison = 0; rd_buf_par_err = 0;
    endtask

    // Applies current inputs for one clock and compares the registered results.
    task automatic tick();
        bit acc, use_ecc;
        acc = in_valid && buf_wr_ready;
        chk("R1", "in_ready", DW'(in_ready), DW'(buf_wr_ready));
        x_wr_en  = acc;
        x_poison = acc && (in_fifo_par_err || in_flit_ecc_err);
        x_evp    = acc && in_fifo_par_err;
        x_eve    = acc && in_flit_ecc_err;
        if (acc) x_wr_data = in_data;
        use_ecc = mdl_ecc_mode;
        if (rd_valid && rd_first) begin
            use_ecc = cfg_ecc_en;
            mdl_ecc_mode = cfg_ecc_en;
        end
        x_mv  = rd_valid;
        x_evb = rd_valid && rd_buf_par_err;
        if (rd_valid) begin
            x_md = rd_data;
            if (use_ecc) begin
                x_be  = '1;
                x_ecc = byte_parity(rd_data);
                if (rd_poison) x_ecc = x_ecc ^ EW'(3);
            end else begin
                x_be  = rd_poison ? '0 : '1;
                x_ecc = '0;
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk("R1", "buf_wr_en", DW'(buf_wr_en), DW'(x_wr_en));
        if (x_wr_en) begin
            chk("R1", "buf_wr_data", buf_wr_data, x_wr_data);
            chk("R2", "buf_wr_poison", DW'(buf_wr_poison), DW'(x_poison));
        end
        chk("R3", "ev_fifo_par", DW'(ev_fifo_par), DW'(x_evp));
        chk("R3", "ev_flit_ecc", DW'(ev_flit_ecc), DW'(x_eve));
        chk("R4", "mem_valid", DW'(mem_valid), DW'(x_mv));
        chk("R11", "ev_buf_par", DW'(ev_buf_par), DW'(x_evb));
        if (x_mv) begin
            chk("R5", "mem_data", mem_data, x_md);
            chk("R6_R7_R8_R9_R10", "mem_byte_en", DW'(mem_byte_en), DW'(x_be));
            chk("R5_R6_R7_R8_R10", "mem_ecc", DW'(mem_ecc), DW'(x_ecc));
        end
    endtask

    task automatic wr(input logic [DW-1:0] d, input bit par, input bit ecc);
        idle();
        in_valid = 1; in_data = d; in_fifo_par_err = par; in_flit_ecc_err = ecc;
        tick();
    endtask

    task automatic rd(input bit first, input logic [DW-1:0] d, input bit poison, input bit bp);
        idle();
        rd_valid = 1; rd_first = first; rd_data = d; rd_poison = poison; rd_buf_par_err = bp;
        tick();
    endtask

    initial begin
        mdl_ecc_mode = 0;
        idle();
        buf_wr_ready = 1; cfg_ecc_en = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12", "buf_wr_en", DW'(buf_wr_en), '0);
        chk("R12", "buf_wr_poison", DW'(buf_wr_poison), '0);
        chk("R12", "mem_valid", DW'(mem_valid), '0);
        chk("R12", "events", DW'({ev_fifo_par, ev_flit_ecc, ev_buf_par}), '0);
        rst_n = 1;
        idle(); tick();

        // R1 R2 R3: each flag pattern on accepted beats
        wr(64'h0123_4567_89ab_cdef, 0, 0);
        wr(64'hdead_beef_0000_1111, 1, 0);
        wr(64'hffff_0000_ffff_0000, 0, 1);
        wr(64'h5555_aaaa_5555_aaaa, 1, 1);
        // R1 R3: buffer not ready, flags must not show
        buf_wr_ready = 0;
        wr(64'h1111_2222_3333_4444, 1, 1);
        wr(64'h9999_8888_7777_6666, 1, 0);
        buf_wr_ready = 1;
        idle(); tick();

        // R10: mask mode right after reset, no first beat yet
        rd(0, 64'h00ff_00ff_00ff_00ff, 1, 0);
        // R6 R7: ECC burst with clean and poisoned beats
        cfg_ecc_en = 1;
        rd(1, 64'h0123_4567_89ab_cdef, 0, 0);
        rd(0, 64'h0f0f_0f0f_1234_5678, 1, 0);
        cfg_ecc_en = 0; // R10: mid-burst change ignored
        rd(0, 64'haaaa_bbbb_cccc_dddd, 1, 0);
        rd(0, 64'h1357_9bdf_2468_ace0, 0, 1); // R11
        // R8 R9: mask burst
        rd(1, 64'h7777_7777_7777_7777, 1, 0);
        cfg_ecc_en = 1; // R10: ignored until next first beat
        rd(0, 64'h0000_0000_0000_0001, 0, 0);
        rd(0, 64'hffff_ffff_ffff_ffff, 1, 1);
        idle(); tick();
        rd(1, 64'hffff_ffff_ffff_ffff, 1, 1);

        // R4: random mix on both sides with gaps
        for (int n = 0; n < 400; n++) begin
            buf_wr_ready    = 1'($urandom_range(0, 3) != 0);
            in_valid        = 1'($urandom_range(0, 1));
            in_data         = {$urandom, $urandom};
            in_fifo_par_err = 1'($urandom_range(0, 3) == 0);
            in_flit_ecc_err = 1'($urandom_range(0, 3) == 0);
            cfg_ecc_en      = 1'($urandom_range(0, 1));
            rd_valid        = 1'($urandom_range(0, 2) != 0);
            rd_first        = 1'($urandom_range(0, 3) == 0);
            rd_data         = {$urandom, $urandom};
            rd_poison       = 1'($urandom_range(0, 2) == 0);
            rd_buf_par_err  = 1'($urandom_range(0, 4) == 0);
            tick();
        end
        idle(); tick();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule